// File: doc/BRIEF.md
# Two-Wire Bus Master Control Front-End

This block is the memory-mapped control core of a master for a two-wire bus to power-management devices. Software talks to it through 32-bit register writes and combinational register reads. It holds the command, the device and register addresses, the data word and the clock settings. A start request from software becomes a single request pulse toward a separate serial engine, which carries out the transfer and answers with a done pulse. The result is reported through a self-clearing busy bit and a status register.

The block also drives a device-mode initialisation request and a soft reset that clears every register. The transfer width and kind come from fixed 8-bit opcodes. One of these opcodes assigns a runtime address to a device. The divider and data-delay fields go straight out to the serial engine's clock generator.

Register map used here (offset, bits): 0x00 control (bit 0 soft reset, bit 7 start); 0x04 clock (7:0 divider N, 10:8 data delay); 0x0C status; 0x10 device register address (7:0); 0x1C data word; 0x28 mode init (23:0 mode value, bit 31 start/busy); 0x2C opcode (7:0); 0x30 device address (15:0 hardware address, 23:16 runtime address).

Top module: `twb_ctrl_front`

## Requirements
- R1: After reset, every register reads 0 and eng_req and eng_mode_req are low.
- R2: A write to offset 0x04 stores bits 10:0 and reads back with the upper bits 0. clk_div shows bits 7:0, which give a bus clock of source/(2*(N+1)). dout_dly shows bits 10:8.
- R3: Writing control bit 7 with a valid opcode gives eng_req high for exactly the one cycle after the write. Control bit 7 reads 1 and status reads 0 until the engine's done pulse.
- R4: Valid opcodes are 0x8B/0x9C/0xA6 (read 8/16/32 bits), 0x4E/0x59/0x63 (write 8/16/32 bits) and 0xE8 (set runtime address). eng_rt_addr is bits 23:16 of offset 0x30. eng_hw_addr is bits 15:0 of that register for 0xE8 and 0 otherwise. eng_reg_addr is bits 7:0 of 0x10. eng_wdata is the data word cut to the write width, and 0 for non-write opcodes.
- R5: A done pulse with eng_err low leaves status 0x01 and clears control bit 7. With eng_err high, status becomes 0x02.
- R6: On a successful read, the data word at 0x1C takes eng_rdata cut to 8, 16 or 32 bits, with zeros above. After a write, an error or a set-address command, the data word is unchanged.
- R7: An unknown opcode raises no eng_req. Status reads 0x03 and control bit 7 reads 0 from the cycle after the start write.
- R8: A start write while a transaction is in flight is ignored: no second eng_req pulse.
- R9: Writing offset 0x28 with bit 31 set, while no mode init is running, stores bits 23:0 and pulses eng_mode_req for one cycle with eng_mode_val equal to them. Bit 31 reads 1 until eng_mode_done. A second write while busy is ignored.
- R10: Writing control bit 0 clears every register at once and aborts any transaction. Bit 0 then reads 1 for RST_CYCLES cycles (default 4), then 0. A done pulse arriving later leaves status at 0.
- R11: Bus writes made while the soft reset is running are ignored, and a start made then raises no eng_req.
- R12: Offsets 0x08, 0x18 and 0x24, and any other offset not mapped, read 0 and ignore writes.
- R13: A done pulse with no transaction in flight changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| clk_div | output | 8 | Divider value N |
| dout_dly | output | 3 | Data output delay in source cycles |
| eng_req | output | 1 | One-cycle transaction request |
| eng_op | output | 8 | Opcode |
| eng_hw_addr | output | 16 | Hardware device address (set-address only) |
| eng_rt_addr | output | 8 | Runtime device address |
| eng_reg_addr | output | 8 | Device register address |
| eng_wdata | output | 32 | Write data cut to width |
| eng_done | input | 1 | Transaction done pulse |
| eng_rdata | input | 32 | Read data with done |
| eng_err | input | 1 | Error flag with done |
| eng_mode_req | output | 1 | One-cycle mode-init request |
| eng_mode_val | output | 24 | Mode value |
| eng_mode_done | input | 1 | Mode-init done pulse |

## Verification
A stuck busy flag shows as control bit 7 still reading 1 on the first read after the done pulse, and it also blocks the next start's request. A wrong latched width shows in the data word on that same read. A wrong opcode decode shows as a request pulse or a status code one cycle after the start write. A soft-reset counter that is off by one shows as bit 0 changing one cycle early or late. A missed clear shows as a nonzero register on the first read after the reset.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int WORD_W = 32;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_CLK    = 8'h04;
  localparam logic [7:0] OFS_STAT   = 8'h0C;
  localparam logic [7:0] OFS_REGADR = 8'h10;
  localparam logic [7:0] OFS_DATA   = 8'h1C;
  localparam logic [7:0] OFS_MODE   = 8'h28;
  localparam logic [7:0] OFS_CMD    = 8'h2C;
  localparam logic [7:0] OFS_DEVADR = 8'h30;

  localparam logic [7:0] OP_SET_RTA = 8'hE8;
  localparam logic [7:0] OP_RD8     = 8'h8B;
  localparam logic [7:0] OP_RD16    = 8'h9C;
  localparam logic [7:0] OP_RD32    = 8'hA6;
  localparam logic [7:0] OP_WR8     = 8'h4E;
  localparam logic [7:0] OP_WR16    = 8'h59;
  localparam logic [7:0] OP_WR32    = 8'h63;

  localparam logic [7:0] ST_OK      = 8'h01;
  localparam logic [7:0] ST_ENG_ERR = 8'h02;
  localparam logic [7:0] ST_BAD_OP  = 8'h03;

  typedef enum logic [1:0] {W_NONE, W_8, W_16, W_32} xfer_width_e;

  typedef struct packed {
    logic        valid;
    logic        is_read;
    logic        is_write;
    logic        is_srta;
    xfer_width_e width;
  } op_info_t;

  function automatic op_info_t decode_op(input logic [7:0] op);
    op_info_t i;
    i = '{valid: 1'b0, is_read: 1'b0, is_write: 1'b0, is_srta: 1'b0, width: W_NONE};
    case (op)
      OP_SET_RTA: begin i.valid = 1'b1; i.is_srta  = 1'b1; end
      OP_RD8:     begin i.valid = 1'b1; i.is_read  = 1'b1; i.width = W_8;  end
      OP_RD16:    begin i.valid = 1'b1; i.is_read  = 1'b1; i.width = W_16; end
      OP_RD32:    begin i.valid = 1'b1; i.is_read  = 1'b1; i.width = W_32; end
      OP_WR8:     begin i.valid = 1'b1; i.is_write = 1'b1; i.width = W_8;  end
      OP_WR16:    begin i.valid = 1'b1; i.is_write = 1'b1; i.width = W_16; end
      OP_WR32:    begin i.valid = 1'b1; i.is_write = 1'b1; i.width = W_32; end
      default:    i.valid = 1'b0;
    endcase
    return i;
  endfunction

  function automatic logic [WORD_W-1:0] cut_width(input xfer_width_e w,
                                                  input logic [WORD_W-1:0] d);
    case (w)
      W_8:     return {24'h0, d[7:0]};
      W_16:    return {16'h0, d[15:0]};
      W_32:    return d;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/twb_srst.sv
module twb_srst #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (kick) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(RST_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  // R10
  srst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> busy_q);
endmodule

// File: rtl/twb_xfer.sv
module twb_xfer
  import twb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic [7:0] op,
  input  logic       eng_done,
  input  logic       eng_err,
  output logic       busy,
  output logic       eng_req,
  output logic [7:0] stat,
  output logic       capture,
  output xfer_width_e cap_width
);
  op_info_t    info;
  logic        busy_q, busy_d, req_q, req_d, rd_q, rd_d;
  logic [7:0]  stat_q, stat_d;
  xfer_width_e wid_q, wid_d;
  logic        accept, finish;

  assign info   = decode_op(op);
  assign accept = start && !busy_q && !abort;
  assign finish = busy_q && eng_done && !abort;

  always_comb begin
    busy_d = busy_q;
    req_d  = 1'b0;
    stat_d = stat_q;
    rd_d   = rd_q;
    wid_d  = wid_q;
    if (abort) begin
      busy_d = 1'b0;
      stat_d = '0;
      rd_d   = 1'b0;
      wid_d  = W_NONE;
    end else if (accept) begin
      if (info.valid) begin
        busy_d = 1'b1;
        req_d  = 1'b1;
        stat_d = '0;
        rd_d   = info.is_read;
        wid_d  = info.width;
      end else begin
        stat_d = ST_BAD_OP;
      end
    end else if (finish) begin
      busy_d = 1'b0;
      stat_d = eng_err ? ST_ENG_ERR : ST_OK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      stat_q <= '0;
      rd_q   <= 1'b0;
      wid_q  <= W_NONE;
    end else begin
      busy_q <= busy_d;
      req_q  <= req_d;
      stat_q <= stat_d;
      rd_q   <= rd_d;
      wid_q  <= wid_d;
    end
  end

  assign busy      = busy_q;
  assign eng_req   = req_q;
  assign stat      = stat_q;
  assign capture   = finish && rd_q && !eng_err;
  assign cap_width = wid_q;

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  // R3
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> busy_q);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy_q) |=> !req_q);
  // R5
  done_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !eng_err) |=> (stat_q == ST_OK && !busy_q));
  // R7
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !info.valid) |=> (stat_q == ST_BAD_OP && !req_q));
endmodule

// File: rtl/twb_mode.sv
module twb_mode (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic        clear,
  input  logic        done,
  output logic        busy,
  output logic        req,
  output logic [23:0] mode_val
);
  logic        busy_q, busy_d, req_q, req_d;
  logic [23:0] val_q, val_d;
  logic        take;

  assign take = wr && !busy_q;

  always_comb begin
    busy_d = busy_q;
    req_d  = 1'b0;
    val_d  = val_q;
    if (clear) begin
      busy_d = 1'b0;
      val_d  = '0;
    end else if (take) begin
      val_d = wdata[23:0];
      if (wdata[31]) begin
        busy_d = 1'b1;
        req_d  = 1'b1;
      end
    end else if (busy_q && done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      val_q  <= '0;
    end else begin
      busy_q <= busy_d;
      req_q  <= req_d;
      val_q  <= val_d;
    end
  end

  assign busy     = busy_q;
  assign req      = req_q;
  assign mode_val = val_q;

  // R9
  mode_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !clear) |=> $stable(val_q));
endmodule

// File: rtl/twb_regs.sv
module twb_regs
  import twb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  input  logic        clear,
  input  logic        capture,
  input  xfer_width_e cap_width,
  input  logic [31:0] cap_data,
  output logic [10:0] clk_q,
  output logic [7:0]  regadr_q,
  output logic [31:0] data_q,
  output logic [7:0]  cmd_q,
  output logic [23:0] devadr_q
);
  logic [10:0] clk_d;
  logic [7:0]  regadr_d, cmd_d;
  logic [31:0] data_d;
  logic [23:0] devadr_d;

  always_comb begin
    clk_d    = clk_q;
    regadr_d = regadr_q;
    data_d   = data_q;
    cmd_d    = cmd_q;
    devadr_d = devadr_q;
    if (clear) begin
      clk_d    = '0;
      regadr_d = '0;
      data_d   = '0;
      cmd_d    = '0;
      devadr_d = '0;
    end else begin
      if (wr && addr == OFS_CLK)    clk_d    = wdata[10:0];
      if (wr && addr == OFS_REGADR) regadr_d = wdata[7:0];
      if (wr && addr == OFS_CMD)    cmd_d    = wdata[7:0];
      if (wr && addr == OFS_DEVADR) devadr_d = wdata[23:0];
      if (capture)                  data_d   = cut_width(cap_width, cap_data);
      else if (wr && addr == OFS_DATA) data_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q    <= '0;
      regadr_q <= '0;
      data_q   <= '0;
      cmd_q    <= '0;
      devadr_q <= '0;
    end else begin
      clk_q    <= clk_d;
      regadr_q <= regadr_d;
      data_q   <= data_d;
      cmd_q    <= cmd_d;
      devadr_q <= devadr_d;
    end
  end

  // R10
  regs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cmd_q == '0 && devadr_q == '0 && data_q == '0));
endmodule

// File: rtl/twb_ctrl_front.sv
module twb_ctrl_front
  import twb_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [7:0]  clk_div,
  output logic [2:0]  dout_dly,
  output logic        eng_req,
  output logic [7:0]  eng_op,
  output logic [15:0] eng_hw_addr,
  output logic [7:0]  eng_rt_addr,
  output logic [7:0]  eng_reg_addr,
  output logic [31:0] eng_wdata,
  input  logic        eng_done,
  input  logic [31:0] eng_rdata,
  input  logic        eng_err,
  output logic        eng_mode_req,
  output logic [23:0] eng_mode_val,
  input  logic        eng_mode_done
);
  logic [1:0]  rsync_q;
  logic        rst_s_n;
  logic        srst_busy, wr_ok, srst_kick, start;
  logic        xfer_busy, capture, mode_busy;
  xfer_width_e cap_width;
  logic [7:0]  stat, regadr_q, cmd_q;
  logic [10:0] clk_q;
  logic [31:0] data_q;
  logic [23:0] devadr_q;
  op_info_t    cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  assign wr_ok     = bus_wr && !srst_busy;
  assign srst_kick = wr_ok && bus_addr == OFS_CTRL && bus_wdata[0];
  assign start     = wr_ok && bus_addr == OFS_CTRL && bus_wdata[7] && !bus_wdata[0];

  twb_srst #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk(clk), .rst_n(rst_s_n), .kick(srst_kick), .busy(srst_busy));

  twb_xfer u_xfer (
    .clk(clk), .rst_n(rst_s_n), .start(start), .abort(srst_kick), .op(cmd_q),
    .eng_done(eng_done), .eng_err(eng_err), .busy(xfer_busy), .eng_req(eng_req),
    .stat(stat), .capture(capture), .cap_width(cap_width));

  twb_mode u_mode (
    .clk(clk), .rst_n(rst_s_n), .wr(wr_ok && bus_addr == OFS_MODE),
    .wdata(bus_wdata), .clear(srst_kick), .done(eng_mode_done),
    .busy(mode_busy), .req(eng_mode_req), .mode_val(eng_mode_val));

  twb_regs u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr(wr_ok), .addr(bus_addr), .wdata(bus_wdata),
    .clear(srst_kick), .capture(capture), .cap_width(cap_width),
    .cap_data(eng_rdata), .clk_q(clk_q), .regadr_q(regadr_q), .data_q(data_q),
    .cmd_q(cmd_q), .devadr_q(devadr_q));

  assign cur          = decode_op(cmd_q);
  assign clk_div      = clk_q[7:0];
  assign dout_dly     = clk_q[10:8];
  assign eng_op       = cmd_q;
  assign eng_rt_addr  = devadr_q[23:16];
  assign eng_hw_addr  = cur.is_srta ? devadr_q[15:0] : 16'h0;
  assign eng_reg_addr = regadr_q;
  assign eng_wdata    = cur.is_write ? cut_width(cur.width, data_q) : '0;

  always_comb begin
    case (bus_addr)
      OFS_CTRL:   bus_rdata = {24'h0, xfer_busy, 6'h0, srst_busy};
      OFS_CLK:    bus_rdata = {21'h0, clk_q};
      OFS_STAT:   bus_rdata = {24'h0, stat};
      OFS_REGADR: bus_rdata = {24'h0, regadr_q};
      OFS_DATA:   bus_rdata = data_q;
      OFS_MODE:   bus_rdata = {mode_busy, 7'h0, eng_mode_val};
      OFS_CMD:    bus_rdata = {24'h0, cmd_q};
      OFS_DEVADR: bus_rdata = {8'h0, devadr_q};
      default:    bus_rdata = '0;
    endcase
  end

  // R11
  srst_no_req_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    srst_busy |=> !eng_req);
endmodule

// File: tb/tb_twb_ctrl_front.sv
module tb_twb_ctrl_front;
  localparam int RSTC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  clk_div;
  logic [2:0]  dout_dly;
  logic        eng_req;
  logic [7:0]  eng_op;
  logic [15:0] eng_hw_addr;
  logic [7:0]  eng_rt_addr, eng_reg_addr;
  logic [31:0] eng_wdata;
  logic        eng_done = 1'b0;
  logic [31:0] eng_rdata = '0;
  logic        eng_err = 1'b0;
  logic        eng_mode_req;
  logic [23:0] eng_mode_val;
  logic        eng_mode_done = 1'b0;

  int n_chk = 0, n_fail = 0, req_cnt = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  twb_ctrl_front #(.RST_CYCLES(RSTC)) dut (.*);

  always @(negedge clk) if (eng_req) req_cnt++;

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] saddr;
    logic [7:0]  daddr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        err;
    logic        valid;
    logic [15:0] hw;
    logic [31:0] ewd;
    logic [7:0]  stat;
    logic [31:0] d0;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{8'h8B, 24'h2D3A3A, 8'h12, 32'h0,        32'hDEADBEEF, 1'b0, 1'b1, 16'h0,    32'h0,        8'h01, 32'h000000EF},
    '{8'h9C, 24'h2D0000, 8'h34, 32'h0,        32'h1234ABCD, 1'b0, 1'b1, 16'h0,    32'h0,        8'h01, 32'h0000ABCD},
    '{8'hA6, 24'h2D0001, 8'h56, 32'h0,        32'hCAFEF00D, 1'b0, 1'b1, 16'h0,    32'h0,        8'h01, 32'hCAFEF00D},
    '{8'h4E, 24'h2D0000, 8'h78, 32'hA5C35A5A, 32'hFFFFFFFF, 1'b0, 1'b1, 16'h0,    32'h5A,       8'h01, 32'hA5C35A5A},
    '{8'h59, 24'h2D0000, 8'h9A, 32'h1234BEEF, 32'h0,        1'b0, 1'b1, 16'h0,    32'hBEEF,     8'h01, 32'h1234BEEF},
    '{8'h63, 24'h2D0000, 8'hBC, 32'h89ABCDEF, 32'h0,        1'b0, 1'b1, 16'h0,    32'h89ABCDEF, 8'h01, 32'h89ABCDEF},
    '{8'hE8, 24'h2D03A3, 8'h00, 32'h11111111, 32'h0,        1'b0, 1'b1, 16'h03A3, 32'h0,        8'h01, 32'h11111111},
    '{8'h8B, 24'h2D0000, 8'h12, 32'h00000077, 32'h000000AA, 1'b1, 1'b1, 16'h0,    32'h0,        8'h02, 32'h00000077},
    '{8'h55, 24'h2D0000, 8'h12, 32'h00000042, 32'h0,        1'b0, 1'b0, 16'h0,    32'h0,        8'h03, 32'h00000042}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic done(input logic [31:0] rdat, input logic err);
    @(negedge clk);
    eng_done = 1'b1; eng_rdata = rdat; eng_err = err;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] r;
    int c0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    begin
      logic [7:0] ofs [8] = '{8'h00, 8'h04, 8'h0C, 8'h10, 8'h1C, 8'h28, 8'h2C, 8'h30};
      for (int i = 0; i < 8; i++) begin
        rd(ofs[i], r);
        chk("R1 register after reset", r, 32'h0);
      end
    end
    chk("R1 eng_req idle", {31'h0, eng_req}, 32'h0);
    chk("R1 eng_mode_req idle", {31'h0, eng_mode_req}, 32'h0);

    // R2 clock register
    wr(8'h04, 32'h0000_0305);
    chk("R2 clk_div", {24'h0, clk_div}, 32'h05);
    chk("R2 dout_dly", {29'h0, dout_dly}, 32'h3);
    rd(8'h04, r); chk("R2 readback", r, 32'h305);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, r); chk("R2 upper bits zero", r, 32'h7FF);
    chk("R2 clk_div max", {24'h0, clk_div}, 32'hFF);
    chk("R2 dout_dly max", {29'h0, dout_dly}, 32'h7);

    // R3 R4 R5 R6 R7 vector walk
    for (int v = 0; v < 9; v++) begin
      wr(8'h2C, {24'h0, VEC[v].op});
      wr(8'h30, {8'h0, VEC[v].saddr});
      wr(8'h10, {24'h0, VEC[v].daddr});
      wr(8'h1C, VEC[v].wdata);
      c0 = req_cnt;
      wr(8'h00, 32'h80);
      if (VEC[v].valid) begin
        chk("R3 eng_req pulse", {31'h0, eng_req}, 32'h1);
        chk("R4 eng_op", {24'h0, eng_op}, {24'h0, VEC[v].op});
        chk("R4 eng_rt_addr", {24'h0, eng_rt_addr}, {24'h0, VEC[v].saddr[23:16]});
        chk("R4 eng_hw_addr", {16'h0, eng_hw_addr}, {16'h0, VEC[v].hw});
        chk("R4 eng_reg_addr", {24'h0, eng_reg_addr}, {24'h0, VEC[v].daddr});
        chk("R4 eng_wdata", eng_wdata, VEC[v].ewd);
        rd(8'h00, r); chk("R3 busy bit set", r, 32'h80);
        rd(8'h0C, r); chk("R3 status cleared", r, 32'h0);
        done(VEC[v].rdata, VEC[v].err);
        rd(8'h00, r); chk("R5 busy bit cleared", r, 32'h0);
        rd(8'h0C, r); chk("R5 status code", r, {24'h0, VEC[v].stat});
        rd(8'h1C, r); chk("R6 data word", r, VEC[v].d0);
        chk("R3 one request", req_cnt - c0, 1);
      end else begin
        chk("R7 no request", {31'h0, eng_req}, 32'h0);
        rd(8'h00, r); chk("R7 busy bit clear", r, 32'h0);
        rd(8'h0C, r); chk("R7 bad opcode status", r, {24'h0, VEC[v].stat});
        chk("R7 request count", req_cnt - c0, 0);
      end
    end

    // R12 unmapped offsets
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, r); chk("R12 offset 08", r, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, r); chk("R12 offset 18", r, 32'h0);
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, r); chk("R12 offset 24", r, 32'h0);

    // R8 start while busy
    wr(8'h2C, 32'hA6);
    c0 = req_cnt;
    wr(8'h00, 32'h80);
    wr(8'h00, 32'h80);
    idle(2);
    chk("R8 single request", req_cnt - c0, 1);
    done(32'h0BAD_F00D, 1'b0);
    rd(8'h0C, r); chk("R8 status after done", r, 32'h01);
    rd(8'h1C, r); chk("R8 data after done", r, 32'h0BAD_F00D);

    // R13 stray done
    done(32'h1111_2222, 1'b1);
    rd(8'h0C, r); chk("R13 status unchanged", r, 32'h01);
    rd(8'h1C, r); chk("R13 data unchanged", r, 32'h0BAD_F00D);

    // R9 mode init
    c0 = 0;
    wr(8'h28, 32'h80AB_CDEF);
    chk("R9 mode request", {31'h0, eng_mode_req}, 32'h1);
    chk("R9 mode value", {8'h0, eng_mode_val}, 32'h00AB_CDEF);
    rd(8'h28, r); chk("R9 busy readback", r, 32'h80AB_CDEF);
    chk("R9 request one cycle", {31'h0, eng_mode_req}, 32'h0);
    wr(8'h28, 32'h8000_0001);
    chk("R9 no second request", {31'h0, eng_mode_req}, 32'h0);
    rd(8'h28, r); chk("R9 write while busy ignored", r, 32'h80AB_CDEF);
    @(negedge clk); eng_mode_done = 1'b1;
    @(negedge clk); eng_mode_done = 1'b0;
    rd(8'h28, r); chk("R9 done clears bit 31", r, 32'h00AB_CDEF);

    // R10 soft reset during transaction
    wr(8'h2C, 32'h8B);
    wr(8'h00, 32'h80);
    wr(8'h00, 32'h01);
    bus_addr = 8'h00;
    #1 chk("R10 reset bit set", bus_rdata, 32'h01);
    for (int k = 1; k < RSTC; k++) begin
      @(negedge clk);
      #1 chk("R10 reset bit held", bus_rdata, 32'h01);
    end
    @(negedge clk);
    #1 chk("R10 reset bit clears", bus_rdata, 32'h00);
    begin
      logic [7:0] ofs [6] = '{8'h04, 8'h10, 8'h1C, 8'h28, 8'h2C, 8'h30};
      for (int i = 0; i < 6; i++) begin
        rd(ofs[i], r);
        chk("R10 register cleared", r, 32'h0);
      end
    end
    done(32'hFFFF_FFFF, 1'b0);
    rd(8'h0C, r); chk("R10 late done ignored", r, 32'h0);

    // R11 writes during soft reset
    wr(8'h00, 32'h01);
    c0 = req_cnt;
    wr(8'h2C, 32'h4E);
    wr(8'h00, 32'h80);
    idle(RSTC);
    chk("R11 no request", req_cnt - c0, 0);
    rd(8'h2C, r); chk("R11 opcode write ignored", r, 32'h0);
    rd(8'h00, r); chk("R11 control idle", r, 32'h0);

    summary();
  end
endmodule